// File: doc/BRIEF.md
# Word FIFO and Byte Data Engine

This block moves data between a sixteen-entry FIFO of 32-bit words and a byte-wide card data port. The host side is a small register file: the host sets a transfer length in bytes, then starts the engine by writing a control register with the enable bit set. It moves words through a window of sixteen word addresses that all reach the one FIFO. It can also read the remaining byte count, the remaining word count and a status word.

In the receive direction, bytes that the card offers are packed into FIFO words, lowest byte first. A final word that is only partly filled is flushed when the byte count reaches zero. In the transmit direction, the engine loads words from the FIFO into a hold register and hands them to the card one byte at a time, again lowest byte first. When no word is available, the engine waits without consuming any of the count. The engine turns itself off once the count is zero and the FIFO has drained. The occupancy flags are reported as a receive set or a transmit set, depending on the selected direction.

Top module: `dxfer_engine`

## Requirements
- R1: After reset, the remaining count reads 0, cardRxReady and cardTxValid are low, and the status word reads 0x00000A00 (transmit set, FIFO empty and half-empty).
- R2: The length register (offset 0x00) keeps only bits 15:0. The control register (offset 0x04) keeps only bits 7:0. Writing control with bit 0 (enable) set copies the length into the remaining count (offset 0x08). The count falls by one for each byte moved on the card side.
- R3: With control bit 1 = 1 (receive), card bytes are packed little-endian: the first byte of each group of four lands in bits 7:0 of the FIFO word.
- R4: In receive, when the count reaches zero, a partly filled word is pushed with its unused upper bytes set to zero.
- R5: With control bit 1 = 0 (transmit), each FIFO word is sent to the card as four bytes, starting with bits 7:0.
- R6: In transmit, while the FIFO is empty and no word is held, cardTxValid stays low and the count does not change.
- R7: When the count reaches zero through a byte transfer, status bit 0 (data end) and bit 1 (block end) are set. They stay set until the host writes 1 to the same bits at the status offset 0x10.
- R8: Enable (control bit 0) clears itself only when the count is zero and the FIFO is empty. In receive it stays set until the host has popped every word.
- R9: Status flags follow occupancy N. Transmit set: bit 8 active (enable), bit 9 N<=8, bit 10 N=16, bit 11 N=0, bit 12 N>0. Receive set: bit 13 active, bit 14 N>=8, bit 15 N=16, bit 16 N=0, bit 17 N>0. Only the set that matches the current direction is non-zero.
- R10: The word-count readout (offset 0x0C) returns (count + 3) >> 2.
- R11: Every word address from 0x80 to 0xBC reaches the same FIFO. A host write pushes a word and a host read returns the oldest word and pops it.
- R12: A push to a full FIFO or a pop from an empty one leaves the FIFO unchanged. Such a read returns 0, and status bit 2 is set and stays set until the host writes 1 to it.
- R13: In receive, cardRxReady is low while the FIFO holds 16 words, and returns once the host pops a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (pops when aimed at the FIFO window) |
| hostAddr | input | 8 | Host byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid in the same cycle as hostRdEn |
| cardRxValid | input | 1 | Card offers a received byte |
| cardRxData | input | 8 | Received byte |
| cardRxReady | output | 1 | Engine accepts a received byte |
| cardTxValid | output | 1 | Engine offers a byte for the card |
| cardTxData | output | 8 | Byte for the card |
| cardTxReady | input | 1 | Card accepts the offered byte |

## Verification
The properties assume that the host does not write the control register while it pushes into or pops from the FIFO window. They also assume that the host stays out of the window while the engine is loading a word in transmit, because in that case the engine's FIFO access takes precedence. The stimulus issues one host access at a time. It pushes transmit words only while the engine stalls on an empty FIFO or holds a word, and it pops receive words only between card bytes. Card-side handshakes are driven after one clock edge and sampled before the next, so every byte transfer is unambiguous.

// File: rtl/dxfer_pkg.sv
package dxfer_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [7:0] A_LEN   = 8'h00;
  localparam logic [7:0] A_CTRL  = 8'h04;
  localparam logic [7:0] A_COUNT = 8'h08;
  localparam logic [7:0] A_WORDS = 8'h0C;
  localparam logic [7:0] A_STAT  = 8'h10;

  // strobes from the control side to the FIFO datapath
  typedef struct packed {
    logic              push;
    logic              pop;
    logic              clrErr;
    logic [WORD_W-1:0] pushWord;
  } fifoCmd_t;
endpackage

// File: rtl/dxfer_path.sv
module dxfer_path
  import dxfer_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = PW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  output logic [WORD_W-1:0] headWord,
  output logic [LW-1:0]     level,
  output logic              errFlag
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic isFull, isEmpty, doPush, doPop;

  assign isFull  = (level == LW'(DEPTH));
  assign isEmpty = (level == '0);
  assign doPush  = cmd.push && !isFull;
  assign doPop   = cmd.pop && !isEmpty;
  assign headWord = isEmpty ? '0 : mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= cmd.pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
      if (cmd.clrErr) errFlag <= 1'b0;
      if ((cmd.push && isFull) || (cmd.pop && isEmpty)) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/dxfer_ctrl.sv
module dxfer_ctrl
  import dxfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int LW = $clog2(DEPTH) + 1,
  localparam int HALF = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              cardRxValid,
  input  logic [BYTE_W-1:0] cardRxData,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [BYTE_W-1:0] cardTxData,
  input  logic              cardTxReady,
  input  logic [LW-1:0]     level,
  input  logic [WORD_W-1:0] headWord,
  input  logic              errFlag,
  output fifoCmd_t          cmd,
  output logic              engineOn,
  output logic [LEN_W-1:0]  remCount
);
  logic [LEN_W-1:0]  lenReg;
  logic [7:0]        ctrlReg;
  logic [1:0]        byteIdx;
  logic [WORD_W-1:0] packWord, holdWord, rxWord;
  logic holdValid, dataEnd, blockEnd;
  logic dirRx, inWindow, ctrlWr, statWr, lastByte, wordDone;
  logic rxFire, rxPush, txGo, txLoad, txFire, byteFire, autoOff;
  logic fEmpty, fFull, fHalfE, fHalfF;
  logic [WORD_W-1:0] statusWord;
  logic [LEN_W:0] wordsLeft;

  assign engineOn = ctrlReg[0];
  assign dirRx    = ctrlReg[1];
  assign inWindow = (hostAddr[7:6] == 2'b10) && (hostAddr[1:0] == 2'b00);
  assign ctrlWr   = hostWrEn && (hostAddr == A_CTRL);
  assign statWr   = hostWrEn && (hostAddr == A_STAT);
  assign lastByte = (remCount == LEN_W'(1));
  assign wordDone = lastByte || (byteIdx == 2'd3);

  // receive: pack bytes little-endian
  assign cardRxReady = engineOn && dirRx && (remCount != '0) && (level != LW'(DEPTH));
  assign rxFire = cardRxValid && cardRxReady;
  assign rxWord = packWord | (WORD_W'(cardRxData) << {byteIdx, 3'b000});
  assign rxPush = rxFire && wordDone;

  // transmit: unpack held word lowest byte first
  assign txGo        = engineOn && !dirRx && (remCount != '0);
  assign txLoad      = txGo && !holdValid && (level != '0);
  assign cardTxValid = txGo && holdValid;
  assign cardTxData  = holdWord[{byteIdx, 3'b000} +: BYTE_W];
  assign txFire      = cardTxValid && cardTxReady;
  assign byteFire    = rxFire || txFire;
  assign autoOff     = engineOn && (remCount == '0) && (level == '0) && !holdValid;

  // engine accesses take precedence over the host window
  always_comb begin
    cmd.push     = rxPush || (hostWrEn && inWindow);
    cmd.pushWord = rxPush ? rxWord : hostWrData;
    cmd.pop      = txLoad || (hostRdEn && inWindow);
    cmd.clrErr   = statWr && hostWrData[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg <= '0; ctrlReg <= '0; remCount <= '0; byteIdx <= '0;
      packWord <= '0; holdWord <= '0; holdValid <= 1'b0;
      dataEnd <= 1'b0; blockEnd <= 1'b0;
    end else begin
      if (hostWrEn && hostAddr == A_LEN) lenReg <= hostWrData[LEN_W-1:0];
      if (statWr && hostWrData[0]) dataEnd  <= 1'b0;
      if (statWr && hostWrData[1]) blockEnd <= 1'b0;
      if (ctrlWr) begin
        ctrlReg <= hostWrData[7:0];
        if (hostWrData[0]) begin
          remCount  <= lenReg;
          byteIdx   <= '0;
          packWord  <= '0;
          holdValid <= 1'b0;
        end
      end else begin
        if (autoOff) ctrlReg[0] <= 1'b0;
        if (byteFire) begin
          remCount <= remCount - 1'b1;
          byteIdx  <= wordDone ? 2'd0 : byteIdx + 1'b1;
          if (rxFire) packWord <= rxPush ? '0 : rxWord;
          if (txFire && wordDone) holdValid <= 1'b0;
          if (lastByte) begin
            dataEnd  <= 1'b1;
            blockEnd <= 1'b1;
          end
        end
        if (txLoad) begin
          holdWord  <= headWord;
          holdValid <= 1'b1;
          byteIdx   <= '0;
        end
      end
    end
  end

  // status assembly: only the set for the current direction
  assign fEmpty = (level == '0);
  assign fFull  = (level == LW'(DEPTH));
  assign fHalfE = (level <= LW'(HALF));
  assign fHalfF = (level >= LW'(HALF));

  always_comb begin
    statusWord = '0;
    statusWord[0] = dataEnd;
    statusWord[1] = blockEnd;
    statusWord[2] = errFlag;
    if (dirRx) begin
      statusWord[13] = engineOn;
      statusWord[14] = fHalfF;
      statusWord[15] = fFull;
      statusWord[16] = fEmpty;
      statusWord[17] = !fEmpty;
    end else begin
      statusWord[8]  = engineOn;
      statusWord[9]  = fHalfE;
      statusWord[10] = fFull;
      statusWord[11] = fEmpty;
      statusWord[12] = !fEmpty;
    end
  end

  assign wordsLeft = ({1'b0, remCount} + (LEN_W+1)'(3)) >> 2;

  always_comb begin
    hostRdData = '0;
    if (inWindow) hostRdData = headWord;
    else begin
      case (hostAddr)
        A_LEN:   hostRdData = WORD_W'(lenReg);
        A_CTRL:  hostRdData = WORD_W'(ctrlReg);
        A_COUNT: hostRdData = WORD_W'(remCount);
        A_WORDS: hostRdData = WORD_W'(wordsLeft);
        A_STAT:  hostRdData = statusWord;
        default: hostRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/dxfer_engine.sv
module dxfer_engine
  import dxfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  input  logic              cardRxValid,
  input  logic [BYTE_W-1:0] cardRxData,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [BYTE_W-1:0] cardTxData,
  input  logic              cardTxReady
);
  fifoCmd_t          fifoCmd;
  logic [WORD_W-1:0] headWord;
  logic [LW-1:0]     fifoLevel;
  logic              fifoErr;
  logic              engineOn;
  logic [LEN_W-1:0]  remCount;

  dxfer_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cardRxValid(cardRxValid), .cardRxData(cardRxData), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxData(cardTxData), .cardTxReady(cardTxReady),
    .level(fifoLevel), .headWord(headWord), .errFlag(fifoErr),
    .cmd(fifoCmd), .engineOn(engineOn), .remCount(remCount)
  );

  dxfer_path #(.DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .cmd(fifoCmd),
    .headWord(headWord), .level(fifoLevel), .errFlag(fifoErr)
  );
endmodule

// File: rtl/dxfer_chk.sv
module dxfer_chk
  import dxfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic [7:0]       hostAddr,
  input logic [LW-1:0]    level,
  input logic [LEN_W-1:0] remCount,
  input logic             enable,
  input logic             cardTxValid,
  input logic             cardRxReady
);
  logic ctrlWrite;
  assign ctrlWrite = hostWrEn && (hostAddr == A_CTRL);

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LW'(DEPTH));

  a_r13_full_blocks_rx: assert property (@(posedge clk) disable iff (!rstN)
    (level == LW'(DEPTH)) |-> !cardRxReady);

  a_r6_tx_needs_count: assert property (@(posedge clk) disable iff (!rstN)
    cardTxValid |-> (remCount != '0) && !cardRxReady);

  a_r2_count_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> remCount <= $past(remCount));

  a_r8_off_only_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !ctrlWrite) |=> enable || ($past(remCount) == '0 && $past(level) == '0));
endmodule

bind dxfer_engine dxfer_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .level(fifoLevel), .remCount(remCount), .enable(engineOn),
  .cardTxValid(cardTxValid), .cardRxReady(cardRxReady)
);

// File: tb/dxfer_engine_tb.sv
module dxfer_engine_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic cardRxValid = 1'b0;
  logic [7:0] cardRxData = '0;
  logic cardRxReady, cardTxValid;
  logic [7:0] cardTxData;
  logic cardTxReady = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rxExp[$];
  logic [7:0]  txExp[$];
  logic [31:0] rd;

  always #5 clk = ~clk;

  dxfer_engine u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cardRxValid(cardRxValid), .cardRxData(cardRxData), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxData(cardTxData), .cardTxReady(cardTxReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    d = hostRdData;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  // scoreboard consumer for receive words
  task automatic popCompare(input string req, input logic [7:0] a);
    logic [31:0] got;
    hostRead(a, got);
    if (rxExp.size() == 0) check({req, " queue"}, got, 32'hDEAD_BEEF);
    else check(req, got, rxExp.pop_front());
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(posedge clk); #1;
    cardRxValid = 1'b1; cardRxData = b;
    @(negedge clk);
    while (!cardRxReady) @(negedge clk);
    @(posedge clk); #1;
    cardRxValid = 1'b0;
  endtask

  // monitor: compares each card transmit byte against the expected queue
  always @(negedge clk) begin
    if (rstN && cardTxValid && cardTxReady) begin
      if (txExp.size() == 0) check("R5 unexpected tx byte", {24'b0, cardTxData}, 32'hFF);
      else check("R5 tx byte order", {24'b0, cardTxData}, {24'b0, txExp.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 rxReady", {31'b0, cardRxReady}, 0);
    check("R1 txValid", {31'b0, cardTxValid}, 0);
    hostRead(8'h08, rd); check("R1 count", rd, 0);
    hostRead(8'h10, rd); check("R1 status", rd, 32'h0000_0A00);

    // R11 / R12 / R9: window addresses, fill, overflow, drain
    for (int i = 0; i < 16; i++) begin
      hostWrite(8'h80 + 8'(4 * i), 32'hA000_0000 + 32'(i));
      rxExp.push_back(32'hA000_0000 + 32'(i));
      if (i == 7) begin
        hostRead(8'h10, rd); check("R9 tx half-empty at 8", rd, 32'h0000_1200);
      end
    end
    hostRead(8'h10, rd); check("R9 tx full", rd, 32'h0000_1400);
    hostWrite(8'h9C, 32'h1234_5678);
    hostRead(8'h10, rd); check("R12 overflow err", rd, 32'h0000_1404);
    for (int i = 0; i < 16; i++) popCompare("R11 window order", 8'hBC - 8'(4 * i));
    hostRead(8'h84, rd); check("R12 empty read zero", rd, 0);
    hostWrite(8'h10, 32'h4);
    hostRead(8'h10, rd); check("R12 err clear", rd, 32'h0000_0A00);
    hostWrite(8'h04, 32'h2);
    hostRead(8'h10, rd); check("R9 rx set only", rd, 32'h0001_0000);

    // R2/R3/R4/R10/R7/R8: receive 7 bytes
    hostWrite(8'h00, 32'h0001_0007);
    hostRead(8'h00, rd); check("R2 length 16 bits", rd, 32'h7);
    hostWrite(8'h04, 32'h0000_12F3);
    hostRead(8'h04, rd); check("R2 ctrl 8 bits", rd, 32'hF3);
    hostRead(8'h08, rd); check("R2 count loaded", rd, 7);
    hostRead(8'h0C, rd); check("R10 words for 7", rd, 2);
    for (int b = 1; b <= 5; b++) sendByte(8'(b));
    hostRead(8'h08, rd); check("R2 count after 5", rd, 2);
    hostRead(8'h0C, rd); check("R10 words for 2", rd, 1);
    sendByte(8'd6); sendByte(8'd7);
    rxExp.push_back(32'h0403_0201);
    rxExp.push_back(32'h0007_0605);
    hostRead(8'h10, rd); check("R7 data end rx", rd, 32'h0002_2003);
    hostRead(8'h04, rd); check("R8 enable held while FIFO busy", rd, 32'hF3);
    popCompare("R3 packed word", 8'h80);
    popCompare("R4 partial flush", 8'hA8);
    @(posedge clk);
    hostRead(8'h04, rd); check("R8 auto clear rx", rd, 32'hF2);

    // R13: backpressure with 72 bytes
    hostWrite(8'h10, 32'h7);
    hostWrite(8'h00, 32'd72);
    hostWrite(8'h04, 32'h3);
    for (int b = 0; b < 64; b++) sendByte(8'(b));
    for (int k = 0; k < 18; k++)
      rxExp.push_back({8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 ready low when full", {31'b0, cardRxReady}, 0);
    hostRead(8'h08, rd); check("R13 count held", rd, 8);
    popCompare("R13 pop", 8'h90);
    popCompare("R13 pop", 8'h94);
    @(negedge clk);
    check("R13 ready back", {31'b0, cardRxReady}, 1);
    for (int b = 64; b < 72; b++) sendByte(8'(b));
    for (int i = 0; i < 16; i++) popCompare("R3 bulk order", 8'h80);
    check("R3 queue drained", rxExp.size(), 0);

    // R5/R6/R7/R8: transmit 6 bytes
    hostWrite(8'h10, 32'h7);
    hostWrite(8'h00, 32'd6);
    hostWrite(8'h04, 32'h1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R6 stall no valid", {31'b0, cardTxValid}, 0);
    hostRead(8'h08, rd); check("R6 stall count", rd, 6);
    txExp = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    hostWrite(8'hB0, 32'h4433_2211);
    hostWrite(8'h88, 32'h8877_6655);
    @(posedge clk); #1 cardTxReady = 1'b1;
    repeat (30) @(posedge clk);
    #1 cardTxReady = 1'b0;
    check("R5 all bytes sent", txExp.size(), 0);
    hostRead(8'h08, rd); check("R2 count zero", rd, 0);
    hostRead(8'h04, rd); check("R8 auto clear tx", rd, 32'h0);
    hostRead(8'h10, rd); check("R7 data end tx", rd, 32'h0000_0A03);
    hostWrite(8'h10, 32'h3);
    hostRead(8'h10, rd); check("R7 clear", rd, 32'h0000_0A00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule